// File: doc/BRIEF.md
# Command-Driven Serial Register Port

This block is a three-wire synchronous slave port that lets a host controller reach a bank of 24-bit registers. A measurement core shares the same registers. Each transaction starts with an 8-bit command byte. The port decodes that byte into one of three operations: a register read, a register write, or an action request that it forwards to the core as a one-cycle strobe. A read is followed by 24 data bits shifted out of the port. A write is followed by 24 data bits shifted in, and the register takes the new word only once the last bit has arrived.

The port runs entirely on the system clock. Chip select, serial clock and serial data in all pass through a multi-stage resynchroniser, and the port finds serial clock edges by comparing the resynchronised clock with its value on the previous cycle. The serial clock must therefore stay well below the system clock; each serial half period should last at least four system cycles. The core writes measurement results through a dedicated write port and reads configuration through a combinational read port. One command byte value is reserved for host recovery: it does nothing except leave the port waiting for a new command byte.

Top module: `serial_reg_port`

## Requirements
- R1: `sdo_oe` is low (output floating) whenever `cs_n` has been high for longer than the resynchroniser depth, and high while the port is selected.
- R2: A command byte is 8 bits, taken MSB first on rising serial clock edges while selected. Bit 7 = 0 marks a register access, bit 6 = 1 marks a write and 0 a read, bits 5:1 give the register address, and bit 0 is ignored.
- R3: After a read command, the addressed register's value at decode time appears on `sdo`, MSB first. Each new bit is presented after a falling serial clock edge, so the host can sample it before the next rising edge. The 24 data clocks follow the command byte directly.
- R4: Write data is taken MSB first on rising edges. The addressed register keeps its old value through the first 23 data bits and holds the new word after the 24th bit.
- R5: A command byte with bit 7 = 1, other than 0xFE, produces exactly one system-clock pulse on `action_stb`, with `action_code` equal to command bits 6:0.
- R6: The command byte 0xFE changes no register and raises no strobe, and the very next byte in the same selection is decoded as a command.
- R7: Raising `cs_n` in the middle of a transfer discards it, so a partial write changes nothing. After reselection the first byte is a command.
- R8: Serial clock and data activity while `cs_n` is high has no effect on the registers, the strobe or later framing.
- R9: A core write updates the addressed register on the next system clock edge, and that value is visible on `core_rd_data` and over a serial read. If a serial commit and a core write hit the same register in the same cycle, the serial commit wins.
- R10: After reset all registers read zero, `sdo` is 0, `sdo_oe` is 0 and `action_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for sdo; low means high impedance |
| action_stb | output | 1 | One-cycle pulse for an action command |
| action_code | output | 7 | Action command bits 6:0 |
| core_wr_en | input | 1 | Core register write enable |
| core_wr_addr | input | 5 | Core write address |
| core_wr_data | input | 24 | Core write data |
| core_rd_addr | input | 5 | Core read address |
| core_rd_data | output | 24 | Register contents at core_rd_addr |

## Verification
A serial edge at the pins takes effect two resynchroniser cycles plus one state-register cycle later. A committed write becomes visible on `core_rd_data` one cycle after that, so four system cycles after the last rising edge. Read bits settle on `sdo` the same number of cycles after a falling edge. The bench holds every serial half period for six system cycles and samples `sdo` at the end of the low half, just before it raises the clock. It checks register contents only after a full half period has passed, so every result has arrived before it is sampled. A monitor on the system clock counts action strobes, and strobe checks compare that count before and after each byte.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int CMD_W      = 8;
    localparam int REG_ADDR_W = 5;
    localparam int ACT_W      = 7;
    localparam logic [CMD_W-1:0] RESYNC_CMD = 8'hFE;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_ACTION = 2'd3
    } op_t;

    function automatic op_t decode_cmd(input logic [CMD_W-1:0] c);
        if (c == RESYNC_CMD) return OP_NONE;
        if (c[7])            return OP_ACTION;
        if (c[6])            return OP_WRITE;
        return OP_READ;
    endfunction

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sport_fsm.sv
module sport_fsm
    import sport_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  wr_stb,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  sdo,
    output logic                  act_stb,
    output logic [ACT_W-1:0]      act_code
);

    localparam int CNT_W = $clog2(DATA_W) > 3 ? $clog2(DATA_W) : 3;
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);

    typedef struct packed {
        phase_t                phase;
        logic [CNT_W-1:0]      cnt;
        logic [CMD_W-1:0]      cmd;
        logic [REG_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]     tx;
        logic [DATA_W-1:0]     rx;
        logic                  sdo;
        logic                  sclk_prev;
        logic                  act_stb;
        logic [ACT_W-1:0]      act_code;
        logic                  wr_stb;
        logic [REG_ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0]     wr_data;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;
    logic [CMD_W-1:0] cmd_next;

    assign rise     = sclk_s & ~st_q.sclk_prev;
    assign fall     = ~sclk_s & st_q.sclk_prev;
    assign cmd_next = {st_q.cmd[CMD_W-2:0], sdi_s};
    // bits 5:1 of the byte being completed sit in cmd[4:0] before the last shift
    assign rd_addr  = st_q.cmd[REG_ADDR_W-1:0];

    always_comb begin
        st_d           = st_q;
        st_d.act_stb   = 1'b0;
        st_d.wr_stb    = 1'b0;
        st_d.sclk_prev = sclk_s;

        if (cs_s) begin
            st_d.phase = PH_CMD;
            st_d.cnt   = '0;
            st_d.sdo   = 1'b0;
        end else if (rise) begin
            unique case (st_q.phase)
                PH_CMD: begin
                    st_d.cmd = cmd_next;
                    if (st_q.cnt == LAST_CMD) begin
                        st_d.cnt = '0;
                        unique case (decode_cmd(cmd_next))
                            OP_ACTION: begin
                                st_d.act_stb  = 1'b1;
                                st_d.act_code = cmd_next[ACT_W-1:0];
                            end
                            OP_WRITE: begin
                                st_d.phase = PH_WRITE;
                                st_d.addr  = cmd_next[REG_ADDR_W:1];
                            end
                            OP_READ: begin
                                st_d.phase = PH_READ;
                                st_d.addr  = cmd_next[REG_ADDR_W:1];
                                st_d.tx    = rd_data;
                            end
                            default: ;
                        endcase
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_READ: begin
                    if (st_q.cnt == LAST_DATA) begin
                        st_d.phase = PH_CMD;
                        st_d.cnt   = '0;
                        st_d.sdo   = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_WRITE: begin
                    st_d.rx = {st_q.rx[DATA_W-2:0], sdi_s};
                    if (st_q.cnt == LAST_DATA) begin
                        st_d.wr_stb  = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_data = {st_q.rx[DATA_W-2:0], sdi_s};
                        st_d.phase   = PH_CMD;
                        st_d.cnt     = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_CMD;
                    st_d.cnt   = '0;
                end
            endcase
        end else if (fall && st_q.phase == PH_READ) begin
            st_d.sdo = st_q.tx[DATA_W-1];
            st_d.tx  = {st_q.tx[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_CMD;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_stb   = st_q.wr_stb;
    assign wr_addr  = st_q.wr_addr;
    assign wr_data  = st_q.wr_data;
    assign sdo      = st_q.sdo;
    assign act_stb  = st_q.act_stb;
    assign act_code = st_q.act_code;

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_DATA)
        else $error("bit counter out of range");

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |=> !act_stb)
        else $error("action strobe longer than one cycle");

    assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st_q.phase == PH_CMD && st_q.cnt == '0 && !wr_stb))
        else $error("port not idle after deselect");

    assert_write_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (st_q.phase == PH_CMD && !act_stb))
        else $error("commit outside command phase");

endmodule

// File: rtl/sport_regbank.sv
module sport_regbank
    import sport_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_we,
    input  logic [REG_ADDR_W-1:0] ser_addr,
    input  logic [DATA_W-1:0]     ser_data,
    input  logic                  core_we,
    input  logic [REG_ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0]     core_data,
    input  logic [REG_ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0]     rd_data_a,
    input  logic [REG_ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0]     rd_data_b
);

    localparam int N_REGS = 1 << REG_ADDR_W;

    logic [N_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (core_we && core_addr == REG_ADDR_W'(g)) regs_d[g] = core_data;
            if (ser_we  && ser_addr  == REG_ADDR_W'(g)) regs_d[g] = ser_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_data_a = regs_q[rd_addr_a];
    assign rd_data_b = regs_q[rd_addr_b];

    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_we && !core_we) |=> $stable(regs_q))
        else $error("register changed without a write");

    assert_serial_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_we && core_we && ser_addr == core_addr) |=> (regs_q[$past(ser_addr)] == $past(ser_data)))
        else $error("serial commit lost to core write");

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import sport_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  action_stb,
    output logic [ACT_W-1:0]      action_code,
    input  logic                  core_wr_en,
    input  logic [REG_ADDR_W-1:0] core_wr_addr,
    input  logic [DATA_W-1:0]     core_wr_data,
    input  logic [REG_ADDR_W-1:0] core_rd_addr,
    output logic [DATA_W-1:0]     core_rd_data
);

    logic [2:0] pins_s;
    logic cs_s, sclk_s, sdi_s;
    logic [REG_ADDR_W-1:0] fsm_rd_addr, wr_addr;
    logic [DATA_W-1:0] fsm_rd_data, wr_data;
    logic wr_stb;

    sport_sync #(
        .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, sdi}), .q(pins_s)
    );

    assign {cs_s, sclk_s, sdi_s} = pins_s;

    sport_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .rd_addr(fsm_rd_addr), .rd_data(fsm_rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .act_stb(action_stb), .act_code(action_code)
    );

    sport_regbank #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ser_we(wr_stb), .ser_addr(wr_addr), .ser_data(wr_data),
        .core_we(core_wr_en), .core_addr(core_wr_addr), .core_data(core_wr_data),
        .rd_addr_a(fsm_rd_addr), .rd_data_a(fsm_rd_data),
        .rd_addr_b(core_rd_addr), .rd_data_b(core_rd_data)
    );

    assign sdo_oe = ~cs_s;

    // consecutive cycles with chip select high, saturating past the sync depth
    localparam int HI_W = $clog2(SYNC_STAGES + 2) + 1;
    logic [HI_W-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hi_cnt_q <= '0;
        else if (!cs_n)                          hi_cnt_q <= '0;
        else if (hi_cnt_q <= HI_W'(SYNC_STAGES)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_float_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q > HI_W'(SYNC_STAGES)) |-> !sdo_oe)
        else $error("sdo driven while deselected");

endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, action_stb;
    logic [6:0] action_code;
    logic core_wr_en = 1'b0;
    logic [4:0] core_wr_addr = '0, core_rd_addr = '0;
    logic [23:0] core_wr_data = '0, core_rd_data;

    int checks = 0, fails = 0;
    int stb_cnt = 0;
    logic [6:0] last_code = '0;

    always #2 clk = ~clk;

    serial_reg_port i_serial_reg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .action_stb(action_stb), .action_code(action_code),
        .core_wr_en(core_wr_en), .core_wr_addr(core_wr_addr), .core_wr_data(core_wr_data),
        .core_rd_addr(core_rd_addr), .core_rd_data(core_rd_data)
    );

    always @(posedge clk) if (action_stb) begin
        stb_cnt   <= stb_cnt + 1;
        last_code <= action_code;
    end

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF); cs_n = 1'b1; wait_clk(4 * HALF);
    endtask

    task automatic clock_bit(input logic b, output logic so);
        sdi = b; wait_clk(HALF);
        so = sdo; sclk = 1'b1; wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic so;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], so);
    endtask

    task automatic xfer24(input logic [23:0] din, output logic [23:0] dout);
        logic so;
        for (int i = 23; i >= 0; i--) begin
            clock_bit(din[i], so);
            dout[i] = so;
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [23:0] v);
        logic [23:0] dummy;
        sel(); send_byte({2'b01, a, 1'b0}); xfer24(v, dummy); desel();
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [23:0] v);
        sel(); send_byte({2'b00, a, 1'b0}); xfer24(24'h0, v); desel();
    endtask

    task automatic core_peek(input logic [4:0] a, output logic [23:0] v);
        core_rd_addr = a; wait_clk(1); v = core_rd_data;
    endtask

    // {command byte, write data, expected read data}
    localparam logic [55:0] VEC [9] = '{
        {8'h46, 24'hA5A5A5, 24'h000000},
        {8'h06, 24'h000000, 24'hA5A5A5},
        {8'h07, 24'h000000, 24'hA5A5A5},
        {8'h7E, 24'h800001, 24'h000000},
        {8'h3E, 24'h000000, 24'h800001},
        {8'h40, 24'hFFFFFF, 24'h000000},
        {8'h00, 24'h000000, 24'hFFFFFF},
        {8'h0A, 24'h000000, 24'h000000},
        {8'h46, 24'h123456, 24'h000000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [23:0] v;
        int s0;
        wait_clk(5);
        // R10 reset state
        check("R10 sdo", {23'd0, sdo}, 24'd0);
        check("R10 sdo_oe", {23'd0, sdo_oe}, 24'd0);
        check("R10 strobe", {23'd0, action_stb}, 24'd0);
        rst_n = 1'b1;
        wait_clk(4);
        core_peek(5'd0, v);  check("R10 reg0", v, 24'd0);
        core_peek(5'd31, v); check("R10 reg31", v, 24'd0);
        check("R1 deselected oe", {23'd0, sdo_oe}, 24'd0);

        // R2 R3 R4 table walk
        for (int k = 0; k < 9; k++) begin
            logic [7:0]  c;
            logic [23:0] d, e, r;
            {c, d, e} = VEC[k];
            sel();
            check("R1 selected oe", {23'd0, sdo_oe}, 24'd1);
            send_byte(c);
            xfer24(d, r);
            desel();
            if (!c[6]) check("R3 R2 read data", r, e);
        end
        core_peek(5'd3, v); check("R4 committed reg3", v, 24'h123456);

        // R4 partial write holds old value until bit 24
        begin
            logic so;
            logic [23:0] nv = 24'hC3C3C3;
            sel(); send_byte(8'h4E);
            for (int i = 23; i >= 1; i--) clock_bit(nv[i], so);
            core_peek(5'd7, v); check("R4 before last bit", v, 24'd0);
            clock_bit(nv[0], so);
            core_peek(5'd7, v); check("R4 after last bit", v, 24'hC3C3C3);
            desel();
        end

        // R5 action command
        s0 = stb_cnt;
        sel(); send_byte(8'h85); desel();
        check("R5 strobe count", 24'(stb_cnt - s0), 24'd1);
        check("R5 action code", {17'd0, last_code}, 24'h05);

        // R6 resync byte then read in same selection
        s0 = stb_cnt;
        sel(); send_byte(8'hFE);
        send_byte(8'h06); xfer24(24'h0, v); desel();
        check("R6 no strobe", 24'(stb_cnt - s0), 24'd0);
        check("R6 next byte is command", v, 24'h123456);

        // R7 aborted write
        begin
            logic so;
            sel(); send_byte(8'h46);
            for (int i = 0; i < 10; i++) clock_bit(1'b1, so);
            desel();
            core_peek(5'd3, v); check("R7 no partial commit", v, 24'h123456);
            reg_read(5'd3, v); check("R7 reframed read", v, 24'h123456);
        end

        // R8 activity while deselected
        s0 = stb_cnt;
        for (int i = 0; i < 20; i++) begin
            sdi = 1'b1; sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
        end
        sdi = 1'b0;
        check("R8 no strobe", 24'(stb_cnt - s0), 24'd0);
        check("R1 still floating", {23'd0, sdo_oe}, 24'd0);
        reg_read(5'd3, v); check("R8 framing intact", v, 24'h123456);
        core_peek(5'd31, v); check("R8 reg31 unchanged", v, 24'h800001);

        // R9 core write port
        core_wr_addr = 5'd9; core_wr_data = 24'h0F0F0F; core_wr_en = 1'b1;
        wait_clk(1); core_wr_en = 1'b0;
        core_peek(5'd9, v); check("R9 core read", v, 24'h0F0F0F);
        reg_read(5'd9, v); check("R9 serial read", v, 24'h0F0F0F);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule